// File: doc/BRIEF.md
# Interleaved Multiphase PWM with Current Balancing

This block is the digital modulator of a multiphase buck controller. It drives two, three or four power channels from one shared signed voltage-error word. Each channel also supplies one sampled current word. The block compares each channel's currents with the average of all active channels. A channel that carries more than its share has its compare level lowered by the excess, and a channel that carries less has its level raised. The result is a shorter pulse for a heavy channel and a longer pulse for a light one, which pulls the channel currents back into balance.

One free-running master counter sets the switching period. Each active channel sees that count shifted by an equal fraction of the period, so the channels switch interleaved rather than together. Two strap inputs choose how many channels are active. Inactive channels keep their output-enable low, so their drivers stay three-stated. A new compare level takes effect only when a channel's ramp wraps, which keeps every duty cycle constant for a whole period.

Top module: `mpwm_top`

## Requirements
- R1: Channel count decode. When `strap3_i` is 1, only channels 0 and 1 are active. When `strap3_i` is 0 and `strap4_i` is 1, channels 0 to 2 are active. When both straps are 0, all four channels are active. `oe_o[k]` is 1 exactly for the active channels.
- R2: `pwm_o[k]` is 0 for every inactive channel.
- R3: The master count runs 0, 1, ..., P-1 and then returns to 0, where P is `period_i`. With n active channels, the ramp of active channel k equals (master + floor(k*P/n)) mod P. An inactive channel has an offset of 0.
- R4: `pwm_o[k]` of an active channel is 1 exactly while that channel's ramp is below its latched compare level.
- R5: A channel's current sample takes the value of `cur_i[k*CUR_W +: CUR_W]` at a clock edge only if `pwm_o[k]` was 0 in the cycle before that edge. Otherwise the sample holds.
- R6: The average is floor(sum of the active channels' samples / n). The raw level of channel k is err - (sample_k - average), where err is `err_i` read as a signed value.
- R7: The raw level is clamped to the range 0 to P. A level of 0 or less keeps the channel low for the whole period. A level of P or more keeps it high for the whole period.
- R8: A channel loads its clamped level only at the edge that ends a cycle in which its ramp equals P-1. At every other edge the latched level holds.
- R9: In steady state, a channel with a larger current than another active channel has fewer high cycles per period, and the difference follows from R6.
- R10: A synchronous active-high `rst` clears the master count, all samples and all latched levels, so every `pwm_o` bit is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Ramp period P in clocks (2 or more) |
| err_i | input | ERR_W | Signed shared voltage-error word |
| cur_i | input | CH_MAX*CUR_W | Unsigned per-channel current samples, channel k at bits k*CUR_W upward |
| strap3_i | input | 1 | Strap: 1 selects two-channel operation |
| strap4_i | input | 1 | Strap: 1 (with strap3_i at 0) selects three-channel operation |
| pwm_o | output | CH_MAX | Per-channel PWM bit |
| oe_o | output | CH_MAX | Per-channel output enable; 0 means the driver is three-stated |

## Verification
The hardest case to reach is a sample that stays frozen. A channel held at full duty never has an off cycle, so it keeps a stale current while its inputs change. That stale value then feeds the average used by every other channel. The stimulus gets there by first driving the error far above the period, which pushes all channels to 100% duty. It then changes the current words, and only then brings the error back into range. The reference model in the bench follows the off-time sampling rule cycle by cycle and catches any channel that picks up the new current too early. Mid-period error steps exercise the wrap-only level loading in the same way.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    parameter int CH_MAX = 4;
    parameter int CNT_W  = 10;
    parameter int ERR_W  = 12;
    parameter int CUR_W  = 10;
    localparam int NCNT_W = 3;

    typedef logic [NCNT_W-1:0] nact_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             wrap;
    } ramp_t;

    function automatic nact_t active_count(input logic s3, input logic s4);
        if (s3)      return nact_t'(2);
        else if (s4) return nact_t'(3);
        else         return nact_t'(4);
    endfunction

    function automatic int div_by_count(input int x, input nact_t n);
        case (n)
            nact_t'(2): return x / 2;
            nact_t'(3): return x / 3;
            default:    return x / 4;
        endcase
    endfunction

    function automatic int clamp_level(input int raw, input int p);
        if (raw < 0) return 0;
        if (raw > p) return p;
        return raw;
    endfunction

endpackage

// File: rtl/mpwm_ramp.sv
module mpwm_ramp
    import mpwm_pkg::*;
#(
    parameter int CH = CH_MAX
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     period_i,
    input  nact_t                n_act,
    output logic [CNT_W-1:0]     master_o,
    output ramp_t [CH-1:0]       ramps_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (int'(cnt_q) >= int'(period_i) - 1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign master_o = cnt_q;

    for (genvar k = 0; k < CH; k++) begin : g_phase
        int off_v;
        int pos_v;
        always_comb begin
            if (k < int'(n_act)) begin
                off_v = div_by_count(k * int'(period_i), n_act);
            end else begin
                off_v = 0;
            end
            pos_v = int'(cnt_q) + off_v;
            if (pos_v >= int'(period_i)) begin
                pos_v = pos_v - int'(period_i);
            end
            ramps_o[k].count = CNT_W'(pos_v);
            ramps_o[k].wrap  = (pos_v == int'(period_i) - 1);
        end
    end

endmodule

// File: rtl/mpwm_balance.sv
module mpwm_balance
    import mpwm_pkg::*;
#(
    parameter int CH = CH_MAX
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            period_i,
    input  logic signed [ERR_W-1:0]     err_i,
    input  logic [CH*CUR_W-1:0]         cur_i,
    input  nact_t                       n_act,
    input  logic [CH-1:0]               pwm_i,
    output logic [CH-1:0][CUR_W-1:0]    samp_o,
    output logic [CH-1:0][CNT_W-1:0]    level_next_o
);

    logic [CH-1:0][CUR_W-1:0] samp_q;

    always_ff @(posedge clk) begin
        for (int k = 0; k < CH; k++) begin
            if (rst) begin
                samp_q[k] <= '0;
            end else if (!pwm_i[k]) begin
                samp_q[k] <= cur_i[k*CUR_W +: CUR_W];
            end
        end
    end

    assign samp_o = samp_q;

    int sum_v;
    int avg_v;
    int err_v;
    int raw_v [CH];

    always_comb begin
        sum_v = 0;
        for (int k = 0; k < CH; k++) begin
            if (k < int'(n_act)) begin
                sum_v = sum_v + int'(samp_q[k]);
            end
        end
        avg_v = div_by_count(sum_v, n_act);
        err_v = int'(err_i);
        for (int k = 0; k < CH; k++) begin
            raw_v[k] = err_v - (int'(samp_q[k]) - avg_v);
            level_next_o[k] = CNT_W'(clamp_level(raw_v[k], int'(period_i)));
        end
    end

endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
    import mpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ramp_t            ramp_i,
    input  logic [CNT_W-1:0] level_next_i,
    input  logic             active_i,
    output logic             pwm_o,
    output logic [CNT_W-1:0] level_o
);

    logic [CNT_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (ramp_i.wrap) begin
            level_q <= level_next_i;
        end
    end

    assign level_o = level_q;
    assign pwm_o   = active_i && (ramp_i.count < level_q);

endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
    import mpwm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            period_i,
    input  logic signed [ERR_W-1:0]     err_i,
    input  logic [CH_MAX*CUR_W-1:0]     cur_i,
    input  logic                        strap3_i,
    input  logic                        strap4_i,
    output logic [CH_MAX-1:0]           pwm_o,
    output logic [CH_MAX-1:0]           oe_o
);

    nact_t                         n_act;
    logic [CNT_W-1:0]              master_cnt;
    ramp_t [CH_MAX-1:0]            ramps;
    logic [CH_MAX-1:0][CUR_W-1:0]  samp_vec;
    logic [CH_MAX-1:0][CNT_W-1:0]  lvl_next;
    logic [CH_MAX-1:0][CNT_W-1:0]  lvl_vec;
    logic [CH_MAX-1:0]             wrap_vec;
    logic [CH_MAX-1:0]             active;

    assign n_act = active_count(strap3_i, strap4_i);

    mpwm_ramp #(.CH(CH_MAX)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .n_act    (n_act),
        .master_o (master_cnt),
        .ramps_o  (ramps)
    );

    mpwm_balance #(.CH(CH_MAX)) u_bal (
        .clk          (clk),
        .rst          (rst),
        .period_i     (period_i),
        .err_i        (err_i),
        .cur_i        (cur_i),
        .n_act        (n_act),
        .pwm_i        (pwm_o),
        .samp_o       (samp_vec),
        .level_next_o (lvl_next)
    );

    for (genvar k = 0; k < CH_MAX; k++) begin : g_ch
        assign active[k]   = (k < int'(n_act));
        assign wrap_vec[k] = ramps[k].wrap;
        mpwm_chan u_chan (
            .clk          (clk),
            .rst          (rst),
            .ramp_i       (ramps[k]),
            .level_next_i (lvl_next[k]),
            .active_i     (active[k]),
            .pwm_o        (pwm_o[k]),
            .level_o      (lvl_vec[k])
        );
    end

    assign oe_o = active;

endmodule

// File: rtl/mpwm_checker.sv
module mpwm_checker
    import mpwm_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [CNT_W-1:0]            period_i,
    input logic                        strap3_i,
    input logic [CH_MAX-1:0]           pwm_o,
    input logic [CH_MAX-1:0]           oe_o,
    input logic [CNT_W-1:0]            master_cnt,
    input logic [CH_MAX-1:0][CUR_W-1:0] samp_vec,
    input logic [CH_MAX-1:0][CNT_W-1:0] lvl_vec,
    input logic [CH_MAX-1:0][CNT_W-1:0] lvl_next,
    input logic [CH_MAX-1:0]           wrap_vec
);

    assert_two_phase_R1: assert property (@(posedge clk) disable iff (rst)
        strap3_i |-> (oe_o[CH_MAX-1:2] == '0));

    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(master_cnt) == int'(period_i) - 1) |=> (master_cnt == '0));

    assert_reset_low_R10: assert property (@(posedge clk)
        rst |=> (pwm_o == '0));

    for (genvar k = 0; k < CH_MAX; k++) begin : g_k
        assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
            !oe_o[k] |-> !pwm_o[k]);

        assert_sample_hold_R5: assert property (@(posedge clk) disable iff (rst)
            pwm_o[k] |=> $stable(samp_vec[k]));

        assert_clamp_range_R7: assert property (@(posedge clk) disable iff (rst)
            lvl_next[k] <= period_i);

        assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !wrap_vec[k] |=> $stable(lvl_vec[k]));
    end

endmodule

bind mpwm_top mpwm_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .period_i   (period_i),
    .strap3_i   (strap3_i),
    .pwm_o      (pwm_o),
    .oe_o       (oe_o),
    .master_cnt (master_cnt),
    .samp_vec   (samp_vec),
    .lvl_vec    (lvl_vec),
    .lvl_next   (lvl_next),
    .wrap_vec   (wrap_vec)
);

// File: tb/sim_mpwm_top.sv
module sim_mpwm_top;
    import mpwm_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [CNT_W-1:0]        period = CNT_W'(40);
    logic signed [ERR_W-1:0] err_v = '0;
    logic [CH_MAX*CUR_W-1:0] cur_v = '0;
    logic                    s3 = 1'b1;
    logic                    s4 = 1'b0;
    logic [CH_MAX-1:0]       pwm;
    logic [CH_MAX-1:0]       oe;

    int checks = 0;
    int errors = 0;
    string tag = "R10";
    bit done = 0;

    always #10 clk = ~clk;

    mpwm_top u0 (
        .clk      (clk),
        .rst      (rst),
        .period_i (period),
        .err_i    (err_v),
        .cur_i    (cur_v),
        .strap3_i (s3),
        .strap4_i (s4),
        .pwm_o    (pwm),
        .oe_o     (oe)
    );

    // behavioural reference state
    int m_cnt;
    int m_samp [CH_MAX];
    int m_lvl  [CH_MAX];

    function automatic int ref_n();
        return s3 ? 2 : (s4 ? 3 : 4);
    endfunction

    function automatic int ref_ramp(int k, int n);
        int off;
        off = (k < n) ? (k * int'(period)) / n : 0;
        return (m_cnt + off) % int'(period);
    endfunction

    function automatic bit ref_pwm(int k);
        int n;
        n = ref_n();
        return (k < n) && (ref_ramp(k, n) < m_lvl[k]);
    endfunction

    always @(posedge clk) begin : model
        int n, sum, avg, raw, p;
        int nl [CH_MAX];
        int ns [CH_MAX];
        if (rst) begin
            m_cnt = 0;
            for (int k = 0; k < CH_MAX; k++) begin
                m_samp[k] = 0;
                m_lvl[k]  = 0;
            end
        end else begin
            n = ref_n();
            p = int'(period);
            sum = 0;
            for (int k = 0; k < n; k++) sum += m_samp[k];
            avg = sum / n;
            for (int k = 0; k < CH_MAX; k++) begin
                raw = int'(err_v) - (m_samp[k] - avg);
                if (raw < 0) raw = 0;
                if (raw > p) raw = p;
                nl[k] = (ref_ramp(k, n) == p - 1) ? raw : m_lvl[k];
                ns[k] = ref_pwm(k) ? m_samp[k] : int'(cur_v[k*CUR_W +: CUR_W]);
            end
            for (int k = 0; k < CH_MAX; k++) begin
                m_lvl[k]  = nl[k];
                m_samp[k] = ns[k];
            end
            m_cnt = (m_cnt >= p - 1) ? 0 : m_cnt + 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            for (int k = 0; k < CH_MAX; k++) begin
                check(pwm[k] == ref_pwm(k), tag, int'(pwm[k]), int'(ref_pwm(k)));
            end
            check(oe == CH_MAX'((1 << ref_n()) - 1), "R1", int'(oe), (1 << ref_n()) - 1);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(int p);
        step();
        rst = 1'b1;
        period = CNT_W'(p);
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic set_cur(int c0, int c1, int c2, int c3);
        cur_v = {CUR_W'(c3), CUR_W'(c2), CUR_W'(c1), CUR_W'(c0)};
    endtask

    task automatic count_high(int k, int len, output int hi);
        hi = 0;
        repeat (len) begin
            @(negedge clk);
            if (pwm[k]) hi++;
        end
    endtask

    task automatic rise_gap(int k, output int gap);
        int t;
        bit prev0, prevk, seen;
        seen = 0; t = 0; gap = -1; prev0 = 1; prevk = 1;
        repeat (4 * int'(period)) begin
            @(negedge clk);
            if (seen) t++;
            if (seen && pwm[k] && !prevk && gap < 0) gap = t;
            if (!seen && pwm[0] && !prev0) seen = 1;
            prev0 = pwm[0];
            prevk = pwm[k];
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        int hi, hj, gap, seed;
        // R10: reset state
        tag = "R10";
        repeat (3) @(negedge clk);
        check(pwm == '0, "R10", int'(pwm), 0);
        check(oe == 4'b0011, "R1", int'(oe), 3);
        step();
        rst = 1'b0;

        // R4 / R9: two channels, balanced then unbalanced
        tag = "R4";
        err_v = 12'sd20;
        set_cur(5, 5, 5, 5);
        repeat (120) step();
        tag = "R9";
        set_cur(30, 10, 50, 50);
        repeat (160) step();
        count_high(0, 40, hi);
        count_high(1, 40, hj);
        check(hi == 10, "R9", hi, 10);
        check(hj == 30, "R9", hj, 30);
        check(hi < hj, "R9", hi, hj);
        count_high(2, 40, hi);
        check(hi == 0, "R2", hi, 0);
        count_high(3, 40, hi);
        check(hi == 0, "R2", hi, 0);

        // R6: three channels, odd period, average with division by three
        tag = "R6";
        s3 = 1'b0; s4 = 1'b1;
        do_reset(41);
        set_cur(12, 18, 30, 0);
        repeat (200) step();
        check(oe == 4'b0111, "R1", int'(oe), 7);
        count_high(0, 41, hi);
        check(hi == 28, "R6", hi, 28);
        count_high(2, 41, hi);
        check(hi == 10, "R6", hi, 10);
        count_high(3, 41, hi);
        check(hi == 0, "R2", hi, 0);

        // R3: four channels, phase spacing
        tag = "R3";
        s4 = 1'b0;
        do_reset(40);
        set_cur(8, 8, 8, 8);
        repeat (120) step();
        check(oe == 4'b1111, "R1", int'(oe), 15);
        rise_gap(1, gap);
        check(gap == 30, "R3", gap, 30);
        rise_gap(2, gap);
        check(gap == 20, "R3", gap, 20);

        // R7: clamps at both ends
        tag = "R7";
        err_v = 12'sd500;
        repeat (120) step();
        count_high(3, 40, hi);
        check(hi == 40, "R7", hi, 40);

        // R5: currents change while every channel is held high
        tag = "R5";
        set_cur(40, 0, 0, 0);
        repeat (80) step();
        err_v = 12'sd20;
        repeat (200) step();
        tag = "R7";
        err_v = -12'sd300;
        repeat (120) step();
        count_high(0, 40, hi);
        check(hi == 0, "R7", hi, 0);

        // R8: error steps in mid-period
        tag = "R8";
        err_v = 12'sd25;
        repeat (57) step();
        for (int i = 0; i < 12; i++) begin
            err_v = ERR_W'(5 + 3 * i);
            repeat (13 + i) step();
        end

        // R6: pseudo-random currents and errors in all modes
        tag = "R6";
        seed = 7;
        for (int i = 0; i < 60; i++) begin
            seed = (seed * 1103515 + 12345) & 32'h7fffffff;
            set_cur(seed % 64, (seed >> 6) % 64, (seed >> 12) % 64, (seed >> 18) % 64);
            err_v = ERR_W'(((seed >> 3) % 70) - 10);
            s3 = (i % 3 == 0);
            s4 = (i % 3 == 1);
            repeat (37) step();
        end

        finish_run();
    end

endmodule